// File: doc/BRIEF.md
# Low-Power Clock State Sequencer

This block sits on the host side of a processor and moves it between its reduced-power clock states. It drives three processor-facing controls: an active-low stop-clock request, an active-low sleep request and an enable for the bus clock. It also drives an enable for the secondary interrupt-controller clock, which always moves together with the bus-clock enable. A command port names a target state. The sequencer then walks one level at a time toward that state. At each step it changes one control and waits a fixed latency before it reports the new level.

The levels are strictly nested, from shallow to deep: Normal, Stop Grant, Sleep, Deep Sleep. Each entry step and each exit step waits `STEP_CLKS` cycles. The exit from Deep Sleep is the exception. There, both clock enables return at once and the block waits `RELOCK_CYCLES` cycles on its free-running clock so the processor PLL can lock again. A synchronous system reset releases every request, restarts the clocks and flags the case where the reset arrived while the bus clock was stopped.

Top module: `pwr_clkstate_seq`

## Requirements
- R1: `cmd_target` encodes 0 = Normal, 1 = Stop Grant, 2 = Sleep, 3 = Deep Sleep. `cur_state` reports the last settled level with the same codes, zero-extended to 3 bits. A command is taken on a clock edge where `cmd_valid` is high and `busy` is low. From that edge on, `busy` stays high until the target level is reported.
- R2: A command walks through every intermediate level, and `cur_state` changes by exactly one level per step. The control change for the next step happens one cycle after the previous level is reported, so an ordinary step costs `STEP_CLKS`+1 cycles.
- R3: Entry order: `stop_req_n` falls first. `sleep_req_n` falls only after Stop Grant is reported. `busclk_en` falls only after Sleep is reported. At no time is `sleep_req_n` low while `stop_req_n` is high, and at no time is `busclk_en` low while `sleep_req_n` is high.
- R4: Each entry step reports the deeper level exactly `STEP_CLKS` cycles after its control changes.
- R5: Sleep to Stop Grant is reported `STEP_CLKS` cycles after `sleep_req_n` rises. Stop Grant to Normal is reported `STEP_CLKS` cycles after `stop_req_n` rises.
- R6: Leaving Deep Sleep raises `busclk_en` first, and the bus clock is restarted only from Deep Sleep. Sleep is reported exactly `RELOCK_CYCLES` cycles after `busclk_en` rises.
- R7: `irq_clk_en` equals `busclk_en` in every cycle. It is dropped and restored on the same edge as the bus clock.
- R8: A command presented while `busy` is high is ignored and does not change the final level.
- R9: A command naming the level already reported is accepted with no effect: `busy` stays low and the controls do not move.
- R10: On the first clock edge with `rst` high, `stop_req_n`, `sleep_req_n`, `busclk_en` and `irq_clk_en` all go high, `cur_state` becomes Normal and `busy` goes low. This holds from Sleep as well.
- R11: `rst_err` is set when a reset begins while the bus clock is stopped (Sleep or Deep Sleep reached with `busclk_en` low). It is cleared by any other reset and by the next accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock, never gated |
| rst | input | 1 | Synchronous active-high system reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_target | input | 2 | Requested level (0 Normal, 1 Stop Grant, 2 Sleep, 3 Deep Sleep) |
| stop_req_n | output | 1 | Stop-clock request to the processor, active low |
| sleep_req_n | output | 1 | Sleep request to the processor, active low |
| busclk_en | output | 1 | Bus-clock gate enable; low parks the clock low |
| irq_clk_en | output | 1 | Interrupt-controller clock enable, follows the bus clock |
| cur_state | output | 3 | Last settled level |
| busy | output | 1 | A walk toward the target is in progress |
| rst_err | output | 1 | Reset arrived while the bus clock was stopped |

## Verification
The properties assume reset is held for at least two cycles. The step-latency and one-level properties are masked for the cycle after reset, and a one-cycle pulse would look like a jump of several levels. They also assume the latency parameters are at least one. The bench therefore holds reset for three or more cycles and builds the design with small but distinct step and relock latencies, so that the two windows can be told apart. Commands are driven on falling edges and last one cycle. The busy-time strobes in the bench deliberately name other levels, which tests that they are ignored.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [2:0] {
        LVL_NORMAL = 3'd0,
        LVL_STOPG  = 3'd1,
        LVL_SLEEP  = 3'd2,
        LVL_DEEP   = 3'd3
    } pwr_lvl_e;

    typedef enum logic {
        PH_SETTLED = 1'b0,
        PH_WAIT    = 1'b1
    } phase_e;

    typedef struct packed {
        logic stop_req_n;
        logic sleep_req_n;
        logic busclk_en;
        logic irq_clk_en;
    } pin_set_t;

    // Control levels that hold once a level has been reached.
    function automatic pin_set_t pins_for(pwr_lvl_e lvl);
        pin_set_t p;
        p.stop_req_n  = (lvl == LVL_NORMAL);
        p.sleep_req_n = (lvl == LVL_NORMAL) || (lvl == LVL_STOPG);
        p.busclk_en   = (lvl != LVL_DEEP);
        p.irq_clk_en  = (lvl != LVL_DEEP);
        return p;
    endfunction

    // One level toward the target.
    function automatic pwr_lvl_e step_toward(pwr_lvl_e cur, pwr_lvl_e tgt);
        if (tgt > cur) return pwr_lvl_e'(cur + 3'd1);
        else           return pwr_lvl_e'(cur - 3'd1);
    endfunction

    function automatic pwr_lvl_e lvl_from_cmd(logic [1:0] code);
        return pwr_lvl_e'({1'b0, code});
    endfunction

endpackage

// File: rtl/pcs_step_timer.sv
module pcs_step_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pcs_cmd_gate.sv
module pcs_cmd_gate
    import pcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_target,
    input  logic       busy,
    output pwr_lvl_e   tgt,
    output logic       accept
);
    assign accept = cmd_valid && !busy;

    always_ff @(posedge clk) begin
        if (rst)
            tgt <= LVL_NORMAL;
        else if (accept)
            tgt <= lvl_from_cmd(cmd_target);
    end
endmodule

// File: rtl/pcs_seq_fsm.sv
module pcs_seq_fsm
    import pcs_pkg::*;
#(
    parameter int STEP_CLKS     = 10,
    parameter int RELOCK_CYCLES = 7500,
    parameter int CW            = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  pwr_lvl_e      tgt,
    input  logic          accept,
    input  logic          expired,
    output logic          load,
    output logic [CW-1:0] load_val,
    output pin_set_t      pins,
    output pwr_lvl_e      lvl,
    output logic          busy,
    output logic          rst_err
);
    phase_e   phase;
    pwr_lvl_e nxt_q;
    logic     rst_q;
    logic     clk_off_now;

    assign busy        = (phase == PH_WAIT) || (tgt != lvl);
    assign load        = !rst && (phase == PH_SETTLED) && (tgt != lvl);
    assign load_val    = (lvl == LVL_DEEP) ? CW'(RELOCK_CYCLES - 1) : CW'(STEP_CLKS - 1);
    assign clk_off_now = ((lvl == LVL_SLEEP) || (lvl == LVL_DEEP)) && !pins.busclk_en;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            phase <= PH_SETTLED;
            lvl   <= LVL_NORMAL;
            nxt_q <= LVL_NORMAL;
            pins  <= pins_for(LVL_NORMAL);
            if (!rst_q)
                rst_err <= clk_off_now;
        end else begin
            if (accept)
                rst_err <= 1'b0;
            unique case (phase)
                PH_SETTLED: begin
                    if (tgt != lvl) begin
                        pins  <= pins_for(step_toward(lvl, tgt));
                        nxt_q <= step_toward(lvl, tgt);
                        phase <= PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    if (expired) begin
                        lvl   <= nxt_q;
                        phase <= PH_SETTLED;
                    end
                end
                default: phase <= PH_SETTLED;
            endcase
        end
    end
endmodule

// File: rtl/pwr_clkstate_seq.sv
module pwr_clkstate_seq
    import pcs_pkg::*;
#(
    parameter int STEP_CLKS     = 10,
    parameter int RELOCK_CYCLES = 7500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_target,
    output logic       stop_req_n,
    output logic       sleep_req_n,
    output logic       busclk_en,
    output logic       irq_clk_en,
    output logic [2:0] cur_state,
    output logic       busy,
    output logic       rst_err
);
    localparam int MAXV = (RELOCK_CYCLES > STEP_CLKS) ? RELOCK_CYCLES : STEP_CLKS;
    localparam int CW   = $clog2(MAXV + 1);

    pwr_lvl_e      tgt;
    pwr_lvl_e      lvl;
    pin_set_t      pins;
    logic          accept;
    logic          load;
    logic          expired;
    logic [CW-1:0] load_val;

    pcs_cmd_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_target (cmd_target),
        .busy       (busy),
        .tgt        (tgt),
        .accept     (accept)
    );

    pcs_seq_fsm #(
        .STEP_CLKS     (STEP_CLKS),
        .RELOCK_CYCLES (RELOCK_CYCLES),
        .CW            (CW)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tgt      (tgt),
        .accept   (accept),
        .expired  (expired),
        .load     (load),
        .load_val (load_val),
        .pins     (pins),
        .lvl      (lvl),
        .busy     (busy),
        .rst_err  (rst_err)
    );

    pcs_step_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    assign stop_req_n  = pins.stop_req_n;
    assign sleep_req_n = pins.sleep_req_n;
    assign busclk_en   = pins.busclk_en;
    assign irq_clk_en  = pins.irq_clk_en;
    assign cur_state   = lvl;
endmodule

// File: rtl/pcs_seq_checker.sv
module pcs_seq_checker #(
    parameter int STEP_CLKS     = 10,
    parameter int RELOCK_CYCLES = 7500
) (
    input logic       clk,
    input logic       rst,
    input logic       stop_req_n,
    input logic       sleep_req_n,
    input logic       busclk_en,
    input logic       irq_clk_en,
    input logic [2:0] cur_state,
    input logic       busy
);
    localparam int MAXV = (RELOCK_CYCLES > STEP_CLKS) ? RELOCK_CYCLES : STEP_CLKS;
    localparam int SW   = $clog2(MAXV + 2);
    localparam logic [SW-1:0] SMAX = {SW{1'b1}};

    logic          rst_d;
    logic [3:0]    pins_now;
    logic [3:0]    pins_q;
    logic [SW-1:0] since;

    assign pins_now = {stop_req_n, sleep_req_n, busclk_en, irq_clk_en};

    // Cycles elapsed since the last control change.
    always_ff @(posedge clk) begin
        rst_d  <= rst;
        pins_q <= pins_now;
        if (rst)
            since <= '0;
        else if (pins_now != pins_q)
            since <= SW'(1);
        else if (since != SMAX)
            since <= since + 1'b1;
    end

    p_sleep_needs_stop_r3: assert property (@(posedge clk) disable iff (rst)
        !sleep_req_n |-> !stop_req_n);

    p_clkoff_needs_sleep_r3: assert property (@(posedge clk) disable iff (rst)
        !busclk_en |-> !sleep_req_n);

    p_sleep_from_stopg_r3: assert property (@(posedge clk) disable iff (rst || rst_d)
        $fell(sleep_req_n) |-> $past(cur_state) == 3'd1);

    p_irq_clk_tracks_r7: assert property (@(posedge clk) disable iff (rst)
        irq_clk_en == busclk_en);

    p_one_level_r2: assert property (@(posedge clk) disable iff (rst || rst_d)
        (cur_state != $past(cur_state)) |->
            ((cur_state == $past(cur_state) + 3'd1) || (cur_state + 3'd1 == $past(cur_state))));

    // Covers R4 and R5 (STEP_CLKS) and the relock window of R6.
    p_step_latency_r4: assert property (@(posedge clk) disable iff (rst || rst_d)
        (cur_state != $past(cur_state)) |->
            (since == ((($past(cur_state) == 3'd3) && (cur_state == 3'd2))
                       ? SW'(RELOCK_CYCLES) : SW'(STEP_CLKS))));

    p_restart_from_deep_r6: assert property (@(posedge clk) disable iff (rst || rst_d)
        $rose(busclk_en) |-> $past(cur_state) == 3'd3);

    p_rst_release_r10: assert property (@(posedge clk)
        rst |=> (stop_req_n && sleep_req_n && busclk_en && irq_clk_en
                 && (cur_state == 3'd0) && !busy));
endmodule

bind pwr_clkstate_seq pcs_seq_checker #(
    .STEP_CLKS     (STEP_CLKS),
    .RELOCK_CYCLES (RELOCK_CYCLES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .stop_req_n  (stop_req_n),
    .sleep_req_n (sleep_req_n),
    .busclk_en   (busclk_en),
    .irq_clk_en  (irq_clk_en),
    .cur_state   (cur_state),
    .busy        (busy)
);

// File: tb/pwr_clkstate_seq_tb.sv
module pwr_clkstate_seq_tb_top;
    localparam int STP = 10;
    localparam int RLK = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_target = 2'd0;
    logic       stop_req_n, sleep_req_n, busclk_en, irq_clk_en, busy, rst_err;
    logic [2:0] cur_state;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    always #2 clk = ~clk;

    pwr_clkstate_seq #(.STEP_CLKS(STP), .RELOCK_CYCLES(RLK)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_target  (cmd_target),
        .stop_req_n  (stop_req_n),
        .sleep_req_n (sleep_req_n),
        .busclk_en   (busclk_en),
        .irq_clk_en  (irq_clk_en),
        .cur_state   (cur_state),
        .busy        (busy),
        .rst_err     (rst_err)
    );

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pins_of(int lvl);
        // {stop_req_n, sleep_req_n, busclk_en, irq_clk_en}
        case (lvl)
            0:       return 4'b1111;
            1:       return 4'b0111;
            2:       return 4'b0011;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic int step_cost(int from, int to);
        return (from == 3 && to == 2) ? RLK + 1 : STP + 1;
    endfunction

    // Issue a command and follow the walk; checks step timing, order and end state.
    task automatic go(int target, string req);
        int n = 0;
        int n_last = 0;
        int prev;
        int order_bad = 0;
        int steps = 0;
        int start;
        @(negedge clk);
        start = int'(cur_state);
        prev = start;
        cmd_target = target[1:0];
        cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check({req, " busy after accept"}, int'(busy), (target != start) ? 1 : 0);
        while (busy && n < 2000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if ((!sleep_req_n && stop_req_n) || (!busclk_en && sleep_req_n)) order_bad++;
            if (irq_clk_en != busclk_en) order_bad++;
            if (int'(cur_state) != prev) begin
                // R2 one level per step, R4/R5/R6 latency per step
                check({req, " R2 single level step"},
                      (int'(cur_state) > prev) ? int'(cur_state) - prev : prev - int'(cur_state), 1);
                check({req, " R4 R5 R6 step latency"}, n - n_last, step_cost(prev, int'(cur_state)));
                n_last = n;
                prev = int'(cur_state);
                steps++;
            end
        end
        check({req, " R1 final level"}, int'(cur_state), target);
        check({req, " R2 number of steps"}, steps,
              (target > start) ? target - start : start - target);
        check({req, " R3 R7 control order"}, order_bad, 0);
        check({req, " R3 settled controls"},
              int'({stop_req_n, sleep_req_n, busclk_en, irq_clk_en}), pins_of(target));
    endtask

    task automatic do_reset(int hold);
        @(negedge clk);
        rst = 1'b1;
        repeat (hold) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R10 stop_req_n after reset", int'(stop_req_n), 1);
        check("R10 sleep_req_n after reset", int'(sleep_req_n), 1);
        check("R10 busclk_en after reset", int'(busclk_en), 1);
        check("R10 irq_clk_en after reset", int'(irq_clk_en), 1);
        check("R10 cur_state after reset", int'(cur_state), 0);
        check("R10 busy after reset", int'(busy), 0);
        check("R11 rst_err after power-up reset", int'(rst_err), 0);
    endtask

    task automatic t_walk_down_up();
        go(3, "R2 walk Normal to Deep Sleep");
        go(0, "R6 walk Deep Sleep to Normal");
    endtask

    task automatic t_single_steps();
        go(1, "R4 enter Stop Grant");
        go(2, "R4 enter Sleep");
        go(1, "R5 leave Sleep");
        go(3, "R2 Stop Grant to Deep Sleep");
        go(2, "R6 relock to Sleep");
        go(0, "R5 Sleep to Normal");
    endtask

    task automatic t_ignore_busy();
        @(negedge clk);
        cmd_target = 2'd2;
        cmd_valid = 1'b1;
        @(negedge clk);
        // R8: strobes while busy name other levels
        cmd_target = 2'd0;
        repeat (3) @(negedge clk);
        cmd_target = 2'd3;
        repeat (5) @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
        check("R8 level after ignored commands", int'(cur_state), 2);
        repeat (30) @(negedge clk);
        check("R8 no later movement", int'(cur_state), 2);
        check("R8 busy stays low", int'(busy), 0);
        check("R8 sleep controls held", int'({stop_req_n, sleep_req_n, busclk_en, irq_clk_en}), pins_of(2));
        go(0, "R8 return to Normal");
    endtask

    task automatic t_same_target();
        @(negedge clk);
        cmd_target = 2'd0;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R9 busy for same-level command", int'(busy), 0);
        repeat (5) @(negedge clk);
        check("R9 controls unchanged", int'({stop_req_n, sleep_req_n, busclk_en, irq_clk_en}), pins_of(0));
        check("R9 level unchanged", int'(cur_state), 0);
    endtask

    task automatic t_reset_in_sleep();
        go(2, "R10 reach Sleep");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R10 stop_req_n released at first reset edge", int'(stop_req_n), 1);
        check("R10 sleep_req_n released at first reset edge", int'(sleep_req_n), 1);
        check("R10 level Normal at first reset edge", int'(cur_state), 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 no error for reset from Sleep with clock running", int'(rst_err), 0);
    endtask

    task automatic t_reset_in_deep();
        go(3, "R11 reach Deep Sleep");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R10 bus clock restarted by reset", int'(busclk_en), 1);
        check("R10 irq clock restarted by reset", int'(irq_clk_en), 1);
        check("R10 requests released from Deep Sleep",
              int'({stop_req_n, sleep_req_n}), 3);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 error flagged for reset in Deep Sleep", int'(rst_err), 1);
        go(1, "R11 command after flagged reset");
        check("R11 error cleared by accepted command", int'(rst_err), 0);
        go(0, "R11 back to Normal");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 200000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        do_reset(4);
        @(negedge clk);
        t_reset_state();
        t_same_target();
        t_walk_down_up();
        t_single_steps();
        t_ignore_busy();
        t_reset_in_sleep();
        t_reset_in_deep();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule